// File: doc/BRIEF.md
# Fractional-Prescaled Timebase Counter

This block keeps a free-running timebase count that is twice the bus word wide. Software sets the rate through a prescaler register. On every cycle where the selected input enable is high, the prescaler value is added into a phase accumulator that is one bit narrower than the word. Each carry out of the accumulator is one tick. The output rate is therefore the input rate times the prescaler divided by 2^(WORD_W-1). With the default 32-bit word, a prescaler of 0x8000_0000 gives a 1:1 ratio.

A control register picks which of two input enables drives the accumulator: the crystal enable or an alternate enable. It also picks whether each tick adds 1 or 2 to the count. Software reads the count as two words. A read of the low word captures the high word at the same moment, so the two halves always belong together.

Top module: `tbase_counter`

## Requirements
- R1: After reset the control register reads 0, the prescaler reads 2^(WORD_W-1) (0x8000_0000 at the default width, 0x8000 at WORD_W=16), and both count words read 0.
- R2: Control bit 8 selects the source. 0 selects `xtal_en` and 1 selects `alt_en`. The control register stores only bits 9 and 8, and every other bit reads back as 0.
- R3: On each cycle where the selected enable is high, the effective prescaler is added to the phase accumulator, and a carry out produces one tick. With prescaler P, this gives P/2^(WORD_W-1) ticks per enabled cycle on average (for example, 0x4000 at WORD_W=16 gives one tick every two enabled cycles).
- R4: Control bit 9 sets the step size. 0 makes each tick add 1 to the count, and 1 makes each tick add 2. The count never advances by more than 2 in one cycle.
- R5: Prescaler values above 2^(WORD_W-1) act as exactly 2^(WORD_W-1), which gives one tick on every enabled cycle. The prescaler register reads back the value that was written.
- R6: Reading the low count word captures the high word at that moment. A later read of the high word returns the captured value, even if the count has moved on since.
- R7: On a cycle where the selected enable is low, neither the accumulator nor the count changes, whatever the unselected enable does.
- R8: The register addresses are: 0 for control, 1 for prescaler, 2 for the count low word, and 3 for the captured high word. Writes to addresses 2 and 3 have no effect. Read data appears on `rdata` in the cycle after `rd_en` is sampled.
- R9: A prescaler value of 0 never advances the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_en | input | 1 | Crystal-source input enable |
| alt_en | input | 1 | Alternate-source input enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | WORD_W | Write data |
| rdata | output | WORD_W | Read data, valid one cycle after rd_en |

## Verification
A write to a register changes behaviour from the next input cycle. An enabled input cycle sampled at a clock edge shows up in the count at that same edge. The bench therefore applies every enable burst in full and updates its own rate model for each cycle, and only then issues a read. Each read returns data one cycle after its strobe. The driver queues the expected word when it raises the strobe, and the monitor compares that word at the falling edge one cycle later. The capture test moves the count across a high-word boundary between the low and high reads, so the captured word and the live word differ.

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xtal_en,
  input  logic              alt_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int CW = 2 * WORD_W;
  localparam int PW = WORD_W - 1;
  localparam logic [WORD_W-1:0] UNITY = {1'b1, {PW{1'b0}}};

  logic              sel_alt, step2;
  logic [WORD_W-1:0] presc, hi_hold, ctrl_word;
  logic [PW-1:0]     phase;
  logic [CW-1:0]     count;

  wire              en   = sel_alt ? alt_en : xtal_en;
  wire [WORD_W-1:0] eff  = (presc > UNITY) ? UNITY : presc;
  wire [WORD_W-1:0] sum  = {1'b0, phase} + eff;
  wire              tick = en & sum[WORD_W-1];
  wire [CW-1:0]     inc  = {{(CW-2){1'b0}}, step2, ~step2};

  always_comb begin
    ctrl_word    = '0;
    ctrl_word[8] = sel_alt;
    ctrl_word[9] = step2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_alt <= 1'b0;
      step2   <= 1'b0;
      presc   <= UNITY;
      phase   <= '0;
      count   <= '0;
      hi_hold <= '0;
      rdata   <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          2'd0: begin
            sel_alt <= wdata[8];
            step2   <= wdata[9];
          end
          2'd1: presc <= wdata;
          default: ;
        endcase
      end
      if (en)   phase <= sum[PW-1:0];
      if (tick) count <= count + inc;
      if (rd_en) begin
        case (addr)
          2'd0: rdata <= ctrl_word;
          2'd1: rdata <= presc;
          2'd2: begin
            rdata   <= count[WORD_W-1:0];
            hi_hold <= count[CW-1:WORD_W];
          end
          default: rdata <= hi_hold;
        endcase
      end
    end
  end

  p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count - $past(count)) <= CW'(2));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(count) && $stable(phase)));

  p_full_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && presc >= UNITY) |=> count != $past(count));

  p_zero_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (presc == '0) |=> $stable(count));

  p_hi_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd2) |=> hi_hold == $past(count[CW-1:WORD_W]));

  p_lo_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd2) |=> rdata == $past(count[WORD_W-1:0]));
endmodule

// File: tb/tbase_counter_tb.sv
module tbase_counter_tb;
  localparam int W = 16;
  localparam longint UNITY = 64'h8000;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  logic         clk = 0, rst_n = 0;
  logic         xtal_en = 0, alt_en = 0, wr_en = 0, rd_en = 0;
  logic [1:0]   addr = 0;
  logic [W-1:0] wdata = 0;
  logic [W-1:0] rdata;

  tbase_counter #(.WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .alt_en(alt_en),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #4 clk = ~clk;

  int     checks = 0, errors = 0, cycles = 0;
  item_t  sb[$];
  logic   pend = 0;
  bit     m_alt = 0, m_step = 0;
  longint m_presc = UNITY, m_phase = 0;
  logic [2*W-1:0] m_cnt = 0;
  logic [W-1:0]   m_hi = 0, m_presc_rd = 16'h8000;

  always @(posedge clk) pend <= rd_en;

  always @(negedge clk) begin
    if (pend) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=0x%0h expected=0x%0h", it.tag, rdata, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    if (a == 2'd0) begin m_alt = d[8]; m_step = d[9]; end
    else if (a == 2'd1) begin m_presc = longint'(d); m_presc_rd = d; end
  endtask

  task automatic rd(input logic [1:0] a, input logic [W-1:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic rd_lo(input string tag);
    m_hi = m_cnt[2*W-1:W];
    rd(2'd2, m_cnt[W-1:0], tag);
  endtask

  task automatic run(input bit a, input bit b, input int n);
    for (int i = 0; i < n; i++) begin
      xtal_en = a; alt_en = b;
      @(negedge clk);
      if (m_alt ? b : a) begin
        longint eff, s;
        eff = (m_presc > UNITY) ? UNITY : m_presc;
        s = m_phase + eff;
        if (s >= UNITY) m_cnt = m_cnt + (m_step ? 2 : 1);
        m_phase = s % UNITY;
      end
    end
    xtal_en = 0; alt_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2'd0, 16'h0000, "R1 ctrl reset");
    rd(2'd1, 16'h8000, "R1 prescaler reset");
    rd_lo("R1 count low reset");
    rd(2'd3, 16'h0000, "R1 count high reset");

    wr(2'd2, 16'h1234);
    wr(2'd3, 16'h5678);
    rd_lo("R8 write to count ignored");

    run(0, 1, 10);
    rd_lo("R7 unselected alt enable ignored");
    run(1, 0, 10);
    rd_lo("R3 unity rate on crystal");
    run(1, 0, 3); run(0, 0, 4); run(1, 0, 2);
    rd_lo("R7 gaps in enable hold count");

    wr(2'd1, 16'h4000);
    run(1, 0, 10);
    rd_lo("R3 half rate");
    wr(2'd1, 16'h3000);
    run(1, 0, 13);
    rd_lo("R3 fractional 0.375 rate");

    wr(2'd1, 16'h0000);
    run(1, 1, 20);
    rd_lo("R9 zero prescaler holds count");

    wr(2'd1, 16'hFFFF);
    rd(2'd1, 16'hFFFF, "R5 prescaler readback");
    run(1, 0, 7);
    rd_lo("R5 clamp to one tick per cycle");

    wr(2'd0, 16'hFFFF);
    rd(2'd0, 16'h0300, "R2 only bits 9 and 8 kept");
    wr(2'd0, 16'h0100);
    wr(2'd1, 16'h8000);
    run(1, 0, 9);
    rd_lo("R2 crystal ignored when alt selected");
    run(0, 1, 9);
    rd_lo("R2 alt source drives count");

    wr(2'd0, 16'h0200);
    run(1, 0, 6);
    rd_lo("R4 step of two");
    wr(2'd0, 16'h0000);
    run(1, 0, 5);
    rd_lo("R4 step of one");

    wr(2'd0, 16'h0200);
    run(1, 0, int'((32'h1FFF0 - m_cnt) / 2));
    rd_lo("R6 low word before crossing");
    run(1, 0, 20);
    rd(2'd3, m_hi, "R6 high word captured, not live");
    rd_lo("R6 low word after crossing");
    rd(2'd3, m_hi, "R6 high word after second capture");
    rd(2'd3, 16'h0002, "R6 captured high value after crossing");

    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R8: actual=%0d unread items expected=0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule